// File: doc/BRIEF.md
# GPIO Port with Per-Line Interrupt Routing

This block is a general-purpose I/O port of up to 32 lines behind a simple 32-bit register bus. Each line can be an input or an output. Output lines drive a value that software programs. The pad levels pass through a synchroniser and can be read back as data.

Any line can raise an interrupt. Each line has its own enable, polarity and trigger-kind bits. A per-line routing byte steers the line to one of several interrupt outputs, or to none of them. Lines that share an output are ORed together, so one output can serve a group of lines.

The bus is a single-cycle strobe interface. A write takes effect at the clock edge where `bus_en_i` and `bus_wr_i` are both high. Read data is combinational from the address while `bus_en_i` is high and `bus_wr_i` is low.

Top module: `pio_port`

## Requirements
- R1: After reset, the output-value, direction, enable, polarity and trigger-kind registers read 0. Every routing byte reads 0x80. `pad_oe_o` and `irq_o` are 0.
- R2: One cycle after a write, `pad_oe_o` equals the direction register at offset 0x08 (1 = drive). `pad_o` equals the output-value register at offset 0x04.
- R3: Offset 0x00 returns the pad levels `pad_i` through a two-flop synchroniser. A change becomes readable after the second rising clock edge. Writes to offset 0x00 are ignored.
- R4: Offsets 0x04, 0x08, 0x0C, 0x10 and 0x14 read back the last value written, with bits at or above NLINES reading 0. Offsets 0x18, 0x1C and any address past the routing area read 0, and writes to them have no effect.
- R5: With polarity 0 and trigger kind 0, an enabled line keeps its routed output high while the synchronised input is low. The output rises on the third rising edge after the pad change and falls three edges after the pad returns high.
- R6: With polarity 1 and trigger kind 0, an enabled line keeps its routed output high while the synchronised input is high.
- R7: With polarity 0 and trigger kind 1, each falling edge of the pad gives a one-cycle pulse on the routed output, three edges after the pad change. A rising edge gives nothing.
- R8: With polarity 1 and trigger kind 1, each rising edge gives a one-cycle pulse. A steady high level gives no further pulse.
- R9: Bit n of the enable register (offset 0x0C) gates line n. With the bit at 0 the line never drives an output, and clearing it removes an active level one edge after the write.
- R10: The routing byte for line n sits at offset 0x20 + 4*(n/4), in bits [8*(n%4)+7 : 8*(n%4)]. Its bits [4:0] select the output index. The line is not routed if bit 7 is set or the index is NOUT or greater. All 8 bits read back as written.
- R11: An output is high when at least one enabled, active line is routed to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Bus access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address (word aligned) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data |
| pad_i | input | NLINES | Pad input levels |
| pad_o | output | NLINES | Pad drive values |
| pad_oe_o | output | NLINES | Pad output enables |
| irq_o | output | NOUT | Routed interrupt outputs |

## Verification
The bound checker watches several rules on every cycle:
- the output enables follow each direction write;
- the polarity register holds each written word;
- reads of the data offset match the pads from two edges earlier;
- no output is raised while every line is disabled or unrouted.

Only the directed scenarios can show the rest:
- the exact latency of level and edge interrupts;
- the one-cycle width of edge pulses;
- that a wrong-direction edge is ignored;
- that shared outputs OR their lines;
- that reserved offsets and the data offset ignore writes.

// File: rtl/pio_pkg.sv
package pio_pkg;
   localparam int MAX_LINES = 32;
   localparam int MAX_OUTS  = 32;

   localparam int OFF_DATA  = 'h00;
   localparam int OFF_OUT   = 'h04;
   localparam int OFF_DIR   = 'h08;
   localparam int OFF_MASK  = 'h0C;
   localparam int OFF_POL   = 'h10;
   localparam int OFF_KIND  = 'h14;
   localparam int OFF_ROUTE = 'h20;

   // One routing byte per line
   typedef struct packed {
      logic       unrouted;
      logic [1:0] spare;
      logic [4:0] sel;
   } route_t;

   localparam route_t ROUTE_RESET = '{unrouted: 1'b1, spare: 2'b00, sel: 5'd0};
endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
   import pio_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int ADDR_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bus_en_i,
   input  logic                bus_wr_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [31:0]         bus_wdata_i,
   output logic [31:0]         bus_rdata_o,
   input  logic [NLINES-1:0]   data_i,
   output logic [NLINES-1:0]   out_q,
   output logic [NLINES-1:0]   dir_q,
   output logic [NLINES-1:0]   mask_q,
   output logic [NLINES-1:0]   pol_q,
   output logic [NLINES-1:0]   kind_q,
   output route_t [NLINES-1:0] map_q
);
   localparam int WW     = ADDR_W - 2;
   localparam int MAPW   = (NLINES + 3) / 4;
   localparam int RWORD0 = OFF_ROUTE >> 2;

   logic [WW-1:0] word;
   logic          we;
   logic [31:0]   map_words [MAPW];
   logic          unused_lo;

   assign word      = bus_addr_i[ADDR_W-1:2];
   assign unused_lo = ^bus_addr_i[1:0];
   assign we        = bus_en_i && bus_wr_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         out_q  <= '0;
         dir_q  <= '0;
         mask_q <= '0;
         pol_q  <= '0;
         kind_q <= '0;
         for (int n = 0; n < NLINES; n++) map_q[n] <= ROUTE_RESET;
      end else if (we) begin
         if (word == WW'(OFF_OUT >> 2))  out_q  <= bus_wdata_i[NLINES-1:0];
         if (word == WW'(OFF_DIR >> 2))  dir_q  <= bus_wdata_i[NLINES-1:0];
         if (word == WW'(OFF_MASK >> 2)) mask_q <= bus_wdata_i[NLINES-1:0];
         if (word == WW'(OFF_POL >> 2))  pol_q  <= bus_wdata_i[NLINES-1:0];
         if (word == WW'(OFF_KIND >> 2)) kind_q <= bus_wdata_i[NLINES-1:0];
         for (int n = 0; n < NLINES; n++)
            if (word == WW'(RWORD0 + n / 4)) map_q[n] <= bus_wdata_i[8*(n%4) +: 8];
      end
   end

   always_comb begin
      for (int w = 0; w < MAPW; w++) map_words[w] = '0;
      for (int n = 0; n < NLINES; n++) map_words[n/4][8*(n%4) +: 8] = map_q[n];
   end

   always_comb begin
      bus_rdata_o = '0;
      if (bus_en_i && !bus_wr_i) begin
         if (word == WW'(OFF_DATA >> 2)) bus_rdata_o[NLINES-1:0] = data_i;
         if (word == WW'(OFF_OUT >> 2))  bus_rdata_o[NLINES-1:0] = out_q;
         if (word == WW'(OFF_DIR >> 2))  bus_rdata_o[NLINES-1:0] = dir_q;
         if (word == WW'(OFF_MASK >> 2)) bus_rdata_o[NLINES-1:0] = mask_q;
         if (word == WW'(OFF_POL >> 2))  bus_rdata_o[NLINES-1:0] = pol_q;
         if (word == WW'(OFF_KIND >> 2)) bus_rdata_o[NLINES-1:0] = kind_q;
         for (int w = 0; w < MAPW; w++)
            if (word == WW'(RWORD0 + w)) bus_rdata_o = map_words[w];
      end
   end
endmodule

// File: rtl/pio_irq_detect.sv
module pio_irq_detect #(
   parameter int NLINES = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NLINES-1:0] lvl_i,
   input  logic [NLINES-1:0] mask_i,
   input  logic [NLINES-1:0] pol_i,
   input  logic [NLINES-1:0] kind_i,
   output logic [NLINES-1:0] act_o
);
   logic [NLINES-1:0] prev_q;
   logic [NLINES-1:0] rise, fall, lvl_hit, edg_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= '0;
      else         prev_q <= lvl_i;
   end

   assign rise    = lvl_i & ~prev_q;
   assign fall    = ~lvl_i & prev_q;
   assign lvl_hit = ~(pol_i ^ lvl_i);
   assign edg_hit = (pol_i & rise) | (~pol_i & fall);
   assign act_o   = mask_i & ((kind_i & edg_hit) | (~kind_i & lvl_hit));
endmodule

// File: rtl/pio_irq_route.sv
module pio_irq_route
   import pio_pkg::*;
#(
   parameter int NLINES = 8,
   parameter int NOUT   = 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic [NLINES-1:0]   act_i,
   input  route_t [NLINES-1:0] map_i,
   output logic [NOUT-1:0]     irq_o
);
   logic [NOUT-1:0] hit;

   always_comb begin
      hit = '0;
      for (int k = 0; k < NOUT; k++)
         for (int n = 0; n < NLINES; n++)
            if (act_i[n] && !map_i[n].unrouted && map_i[n].sel == 5'(k)) hit[k] = 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o <= '0;
      else         irq_o <= hit;
   end
endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int NLINES      = 8,
   parameter int NOUT        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_en_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   input  logic [NLINES-1:0] pad_i,
   output logic [NLINES-1:0] pad_o,
   output logic [NLINES-1:0] pad_oe_o,
   output logic [NOUT-1:0]   irq_o
);
   localparam int MAPW   = (NLINES + 3) / 4;
   localparam int TOP_BY = OFF_ROUTE + 4 * MAPW;

   if (NLINES < 1 || NLINES > MAX_LINES) begin : g_bad_lines
      $fatal(1, "pio_port: NLINES out of range");
   end
   if (NOUT < 1 || NOUT > MAX_OUTS) begin : g_bad_outs
      $fatal(1, "pio_port: NOUT out of range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $fatal(1, "pio_port: SYNC_STAGES below 2");
   end
   if (ADDR_W > 30 || (1 << ADDR_W) < TOP_BY) begin : g_bad_addr
      $fatal(1, "pio_port: ADDR_W cannot reach routing area");
   end

   logic [NLINES-1:0]   lvl, out_q, dir_q, mask_q, pol_q, kind_q, act;
   route_t [NLINES-1:0] map_q;

   pio_sync #(.W(NLINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pad_i), .q_o(lvl));

   pio_regfile #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .bus_en_i(bus_en_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
      .data_i(lvl), .out_q(out_q), .dir_q(dir_q), .mask_q(mask_q),
      .pol_q(pol_q), .kind_q(kind_q), .map_q(map_q));

   pio_irq_detect #(.NLINES(NLINES)) u_det (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .mask_i(mask_q),
      .pol_i(pol_q), .kind_i(kind_q), .act_o(act));

   pio_irq_route #(.NLINES(NLINES), .NOUT(NOUT)) u_route (
      .clk_i(clk_i), .rst_ni(rst_ni), .act_i(act), .map_i(map_q), .irq_o(irq_o));

   assign pad_o    = out_q;
   assign pad_oe_o = dir_q;
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk #(
   parameter int NLINES      = 8,
   parameter int NOUT        = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic                bus_en_i,
   input logic                bus_wr_i,
   input logic [ADDR_W-1:0]   bus_addr_i,
   input logic [31:0]         bus_wdata_i,
   input logic [31:0]         bus_rdata_o,
   input logic [NLINES-1:0]   pad_i,
   input logic [NLINES-1:0]   pad_oe_o,
   input logic [NOUT-1:0]     irq_o,
   input logic [NLINES-1:0]   mask_q,
   input logic [NLINES-1:0]   pol_q,
   input logic [8*NLINES-1:0] map_q
);
   logic [1:0] cyc;
   logic       none_routed;
   logic       wr_dir, wr_pol, rd_data;
   logic       unused_chk;

   assign unused_chk = ^bus_wdata_i;
   assign wr_dir  = bus_en_i && bus_wr_i && bus_addr_i == ADDR_W'('h08);
   assign wr_pol  = bus_en_i && bus_wr_i && bus_addr_i == ADDR_W'('h10);
   assign rd_data = bus_en_i && !bus_wr_i && bus_addr_i == ADDR_W'('h00);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cyc <= '0;
      else if (cyc != 3) cyc <= cyc + 2'd1;
   end

   always_comb begin
      none_routed = 1'b1;
      for (int n = 0; n < NLINES; n++)
         if (!map_q[8*n+7] && int'(map_q[8*n +: 5]) < NOUT) none_routed = 1'b0;
   end

   p_oe_follows_dir_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_dir |=> pad_oe_o == $past(bus_wdata_i[NLINES-1:0]));

   p_pol_holds_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_pol |=> pol_q == $past(bus_wdata_i[NLINES-1:0]));

   p_masked_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(mask_q) == '0) |-> irq_o == '0);

   p_unrouted_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(none_routed) |-> irq_o == '0);

   if (SYNC_STAGES == 2) begin : g_sync2
      p_data_two_flop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (cyc >= 2 && rd_data) |-> bus_rdata_o == 32'($past(pad_i, 2)));
   end
endmodule

bind pio_port pio_port_chk #(
   .NLINES(NLINES), .NOUT(NOUT), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_wr_i(bus_wr_i),
   .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
   .pad_i(pad_i), .pad_oe_o(pad_oe_o), .irq_o(irq_o),
   .mask_q(mask_q), .pol_q(pol_q), .map_q(map_q)
);

// File: tb/pio_port_tb_top.sv
`timescale 1ns/1ps
module pio_port_tb_top;
   localparam int NL = 8;
   localparam int NO = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          en = 1'b0, wr = 1'b0;
   logic [7:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NL-1:0] pad = '0;
   logic [NL-1:0] pad_o, pad_oe;
   logic [NO-1:0] irq;
   int            checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   pio_port #(.NLINES(NL), .NOUT(NO)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_wr_i(wr),
      .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .pad_i(pad), .pad_o(pad_o), .pad_oe_o(pad_oe), .irq_o(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic edges(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
      en = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(posedge clk); #1;
      en = 1'b0; wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
      en = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      en = 1'b0;
   endtask

   task automatic do_reset(input logic [NL-1:0] p);
      pad = p; rst_n = 1'b0;
      edges(3);
      rst_n = 1'b1;
      edges(3);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      do_reset('0);
      bus_rd(8'h04, d); chk("R1 out", d, 0);
      bus_rd(8'h08, d); chk("R1 dir", d, 0);
      bus_rd(8'h0C, d); chk("R1 mask", d, 0);
      bus_rd(8'h10, d); chk("R1 pol", d, 0);
      bus_rd(8'h14, d); chk("R1 kind", d, 0);
      bus_rd(8'h20, d); chk("R1 route0", d, 32'h80808080);
      bus_rd(8'h24, d); chk("R1 route1", d, 32'h80808080);
      chk("R1 irq", 32'(irq), 0);
      chk("R1 oe", 32'(pad_oe), 0);
   endtask

   task automatic t_pins;
      do_reset('0);
      bus_wr(8'h08, 32'hFFFF_FF0F);
      chk("R2 oe", 32'(pad_oe), 32'h0F);
      bus_wr(8'h04, 32'h0000_01A5);
      chk("R2 out", 32'(pad_o), 32'hA5);
   endtask

   task automatic t_regs;
      logic [31:0] d;
      do_reset('0);
      bus_wr(8'h10, 32'hFFFF_FFFF); bus_rd(8'h10, d); chk("R4 pol", d, 32'hFF);
      bus_wr(8'h14, 32'hA5A5_A55A); bus_rd(8'h14, d); chk("R4 kind", d, 32'h5A);
      bus_wr(8'h18, 32'hFFFF_FFFF); bus_rd(8'h18, d); chk("R4 reserved", d, 0);
      bus_wr(8'h28, 32'hFFFF_FFFF); bus_rd(8'h28, d); chk("R4 past map", d, 0);
      bus_wr(8'h20, 32'h1234_5678); bus_rd(8'h20, d); chk("R10 route rb", d, 32'h1234_5678);
      bus_rd(8'h24, d); chk("R10 route1 kept", d, 32'h80808080);
      bus_wr(8'h00, 32'hFFFF); bus_rd(8'h00, d); chk("R3 data ro", d, 0);
      pad = 8'h3C;
      edges(1); bus_rd(8'h00, d); chk("R3 one stage", d, 0);
      edges(1); bus_rd(8'h00, d); chk("R3 two stages", d, 32'h3C);
   endtask

   task automatic t_level_low;
      do_reset(8'hFF);
      bus_wr(8'h20, 32'h8080_8001);
      bus_wr(8'h0C, 32'h01);
      edges(3); chk("R5 idle high", 32'(irq), 0);
      pad[0] = 1'b0;
      edges(2); chk("R5 latency", 32'(irq), 0);
      edges(1); chk("R5 asserted", 32'(irq), 4'b0010);
      edges(4); chk("R5 held", 32'(irq), 4'b0010);
      pad[0] = 1'b1;
      edges(3); chk("R5 released", 32'(irq), 0);
      pad[0] = 1'b0;
      edges(3); chk("R9 before mask", 32'(irq), 4'b0010);
      bus_wr(8'h0C, 32'h00);
      edges(1); chk("R9 masked", 32'(irq), 0);
      bus_wr(8'h20, 32'h8080_8081);
      bus_wr(8'h0C, 32'h01);
      edges(3); chk("R10 bit7 unrouted", 32'(irq), 0);
      bus_wr(8'h20, 32'h8080_8005);
      edges(3); chk("R10 index>=NOUT", 32'(irq), 0);
      bus_wr(8'h20, 32'h8080_8003);
      edges(1); chk("R10 reroute", 32'(irq), 4'b1000);
   endtask

   task automatic t_level_high;
      do_reset('0);
      bus_wr(8'h20, 32'h8080_0280);
      bus_wr(8'h10, 32'h02);
      bus_wr(8'h0C, 32'h02);
      edges(3); chk("R6 idle low", 32'(irq), 0);
      pad[1] = 1'b1;
      edges(3); chk("R6 asserted", 32'(irq), 4'b0100);
      pad[1] = 1'b0;
      edges(3); chk("R6 released", 32'(irq), 0);
   endtask

   task automatic t_edges;
      do_reset(8'h08);
      bus_wr(8'h20, 32'h0303_8080);
      bus_wr(8'h10, 32'h04);
      bus_wr(8'h14, 32'h0C);
      bus_wr(8'h0C, 32'h0C);
      edges(3); chk("R8 idle", 32'(irq), 0);
      pad[2] = 1'b1;
      edges(2); chk("R8 latency", 32'(irq), 0);
      edges(1); chk("R8 pulse", 32'(irq), 4'b1000);
      edges(1); chk("R8 one cycle", 32'(irq), 0);
      edges(3); chk("R8 steady high", 32'(irq), 0);
      pad[3] = 1'b0;
      edges(3); chk("R7 pulse", 32'(irq), 4'b1000);
      edges(1); chk("R7 one cycle", 32'(irq), 0);
      pad[3] = 1'b1;
      edges(3); chk("R7 rising ignored", 32'(irq), 0);
      edges(1); chk("R7 rising ignored+1", 32'(irq), 0);
      pad[2] = 1'b0;
      edges(3); chk("R8 falling ignored", 32'(irq), 0);
   endtask

   task automatic t_share;
      do_reset('0);
      bus_wr(8'h24, 32'h8080_0000);
      bus_wr(8'h10, 32'h30);
      bus_wr(8'h0C, 32'h30);
      pad[4] = 1'b1;
      edges(3); chk("R11 first line", 32'(irq), 4'b0001);
      pad[5] = 1'b1;
      edges(3); chk("R11 both", 32'(irq), 4'b0001);
      pad[4] = 1'b0;
      edges(3); chk("R11 second only", 32'(irq), 4'b0001);
      pad[5] = 1'b0;
      edges(3); chk("R11 none", 32'(irq), 0);
   endtask

   initial begin
      t_reset();
      t_pins();
      t_regs();
      t_level_low();
      t_level_high();
      t_edges();
      t_share();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule